// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer

This block sits on the host side of a one-time-programmable byte memory that is driven through five strobe lines: an address-reset level, a configuration-reset level, a configuration-increment strobe, an address-increment strobe and an active-low commit strobe. The operation the memory performs is chosen by a count. The configuration register is first cleared, and the increment strobe is then pulsed once for each unit of the operation code. The sequencer accepts one address/data request at a time through a valid/ready handshake. It opens a session and unlocks the memory when it has to. It walks the device address up to the target, commits the byte with a long commit pulse, and then reads the byte back in verify mode and compares it.

When the readback differs, the write is repeated at the same address, up to a set number of times. When that limit is used up, a sticky error flag is raised and the block stops taking requests until reset. All pulse widths, gaps and the long commit time are counted in clock cycles. Code values used: unlock = 2 increment pulses, write = 3, verify = 1.

Top module: `prog_verify_seq`

## Requirements
- R1: After reset, rst_add and rst_conf are low, inc_conf and inc_add are low, phase_n is high, bus_oe is low, req_ready is high, and done and err are low.
- R2: A request is handled with a session restart when no session is open or when the target address is lower than the tracked device address. A restart drives rst_add and rst_conf low for GAP_CYC cycles and then high for GAP_CYC cycles, and the tracked address becomes 0. It then sends 2 inc_conf pulses and a phase_n low pulse of SHORT_CYC cycles to unlock the memory.
- R3: A write drives bus_oe high with bus_out equal to the request data for the whole write. It gives a rst_conf low pulse, then 3 inc_conf pulses, then as many inc_add pulses as target minus tracked address, then a phase_n low pulse of LONG_CYC cycles. bus_out does not change while phase_n is low.
- R4: When the target is one above the tracked address, the write issues exactly one inc_add pulse and does not lower rst_add.
- R5: Each write is followed by a verify: a rst_conf low pulse, 1 inc_conf pulse, a SHORT_CYC phase_n low pulse, and a second rst_conf low pulse. GAP_CYC cycles after that second pulse, bus_in is compared in one check cycle. On a match, done is high for that single cycle and the block returns to idle.
- R6: On a mismatch, the write and verify are repeated with no inc_add pulse, up to RETRY_MAX times.
- R7: When the verify after the last allowed repeat still mismatches, err goes high and stays high, and req_ready stays low. Further requests cause no strobe activity until reset.
- R8: Every strobe pulse (inc_conf, inc_add and the rst_conf low pulse) lasts PULSE_CYC cycles and is followed by GAP_CYC quiet cycles. At most one of the strobes is active in any cycle.
- R9: req_ready is high only while idle, and a request is taken on a cycle where req_valid and req_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | DATA_W | Byte to program |
| done | output | 1 | One-cycle pulse: byte written and verified |
| err | output | 1 | Sticky: retry limit exhausted |
| rst_add | output | 1 | Device address reset level (low clears address and lock) |
| rst_conf | output | 1 | Device configuration reset level (low clears the code) |
| inc_conf | output | 1 | Configuration increment strobe |
| inc_add | output | 1 | Address increment strobe |
| phase_n | output | 1 | Active-low commit strobe |
| bus_out | output | DATA_W | Data driven to the device |
| bus_oe | output | 1 | Host drives the data bus |
| bus_in | input | DATA_W | Data read back from the device |

## Verification
A behavioural model of the pin waveform is compared with the design on every clock, together with a device model that counts strobes and programs its memory only when it is unlocked. Requests are issued in several patterns. A first byte at address 0 shows the restart and unlock with no address step. A sequential byte separates the single-step case from a restart. A forward jump of three addresses checks the count of address pulses. A backward target must restart the session. Readbacks corrupted once, corrupted exactly RETRY_MAX times, and corrupted beyond the limit separate a retry that recovers from the sticky error, and a request presented after the error must leave the pins quiet.

// File: rtl/prog_verify_seq.sv
module prog_verify_seq #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 2,
  parameter int GAP_CYC   = 2,
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 12,
  parameter int RETRY_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic              err,
  output logic              rst_add,
  output logic              rst_conf,
  output logic              inc_conf,
  output logic              inc_add,
  output logic              phase_n,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in
);
  localparam int CNT_W = $clog2(LONG_CYC + SHORT_CYC + PULSE_CYC + GAP_CYC + 1);
  localparam int TRY_W = $clog2(RETRY_MAX + 2);

  typedef enum logic [3:0] {
    S_IDLE, S_RA_LOW, S_SETTLE, S_CLR, S_CLR_GAP, S_INC, S_INC_GAP,
    S_ADDR, S_ADDR_GAP, S_PHASE, S_PH_GAP, S_CHECK
  } st_t;
  typedef enum logic [1:0] {OP_UNLOCK, OP_WRITE, OP_VERIFY, OP_READ} op_t;

  st_t               state, nxt;
  op_t               op;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        npul;
  logic [TRY_W-1:0]  tries;
  logic [ADDR_W-1:0] cur, tgt;
  logic [DATA_W-1:0] dat;
  logic              ra_q, rc_q, err_q;

  wire accept  = req_valid && req_ready;
  wire restart = !ra_q || (req_addr < cur);
  wire match   = (bus_in == dat);

  function automatic int dur(st_t s, op_t o);
    case (s)
      S_RA_LOW, S_SETTLE, S_CLR_GAP, S_INC_GAP, S_ADDR_GAP, S_PH_GAP: return GAP_CYC;
      S_CLR, S_INC, S_ADDR: return PULSE_CYC;
      S_PHASE: return (o == OP_WRITE) ? LONG_CYC : SHORT_CYC;
      default: return 1;
    endcase
  endfunction

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:     nxt = accept ? (restart ? S_RA_LOW : S_CLR) : S_IDLE;
      S_RA_LOW:   nxt = S_SETTLE;
      S_SETTLE:   nxt = S_INC;
      S_CLR:      nxt = S_CLR_GAP;
      S_CLR_GAP:  nxt = (op == OP_READ) ? S_CHECK : S_INC;
      S_INC:      nxt = S_INC_GAP;
      S_INC_GAP:  nxt = (npul > 2'd1) ? S_INC :
                        (op == OP_WRITE && cur != tgt) ? S_ADDR : S_PHASE;
      S_ADDR:     nxt = S_ADDR_GAP;
      S_ADDR_GAP: nxt = (cur != tgt) ? S_ADDR : S_PHASE;
      S_PHASE:    nxt = S_PH_GAP;
      S_PH_GAP:   nxt = S_CLR;
      S_CHECK:    nxt = (match || tries == TRY_W'(RETRY_MAX)) ? S_IDLE : S_CLR;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; op <= OP_UNLOCK; cnt <= '0; npul <= '0; tries <= '0;
      cur <= '0; tgt <= '0; dat <= '0; ra_q <= 1'b0; rc_q <= 1'b0; err_q <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      state <= nxt;
      cnt   <= CNT_W'(dur(nxt, op) - 1);
      case (state)
        S_IDLE: if (accept) begin
          tgt <= req_addr; dat <= req_data; tries <= '0;
          op  <= restart ? OP_UNLOCK : OP_WRITE;
        end
        S_RA_LOW:  begin ra_q <= 1'b1; rc_q <= 1'b1; cur <= '0; end
        S_SETTLE:  npul <= 2'd2;
        S_CLR_GAP: npul <= (op == OP_WRITE) ? 2'd3 : 2'd1;
        S_INC_GAP: if (npul > 2'd1) npul <= npul - 2'd1;
        S_ADDR:    cur <= cur + ADDR_W'(1);
        S_PH_GAP:  op <= (op == OP_UNLOCK) ? OP_WRITE : (op == OP_WRITE) ? OP_VERIFY : OP_READ;
        S_CHECK: if (!match) begin
          if (tries == TRY_W'(RETRY_MAX)) err_q <= 1'b1;
          else begin tries <= tries + 1'b1; op <= OP_WRITE; end
        end
        default: ;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE) && !err_q;
  assign done      = (state == S_CHECK) && match;
  assign err       = err_q;
  assign rst_add   = ra_q && (state != S_RA_LOW);
  assign rst_conf  = rc_q && (state != S_RA_LOW) && (state != S_CLR);
  assign inc_conf  = (state == S_INC);
  assign inc_add   = (state == S_ADDR);
  assign phase_n   = (state != S_PHASE);
  assign bus_oe    = (op == OP_WRITE) && (state != S_IDLE);
  assign bus_out   = dat;

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_conf, inc_add, !phase_n, rst_add && !rst_conf}));
  p_bus_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_n && bus_oe) |-> $stable(bus_out));
  p_step_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inc_add |-> (bus_oe && rst_add));
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !req_ready);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_take_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/tb_prog_verify_seq.sv
module tb_prog_verify_seq;
  localparam int AW = 8, DW = 8, P = 2, G = 2, S = 3, L = 12, RM = 2;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, err, rst_add, rst_conf, inc_conf, inc_add, phase_n, bus_oe;
  logic [DW-1:0] bus_out, bus_in;

  prog_verify_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(P), .GAP_CYC(G),
    .SHORT_CYC(S), .LONG_CYC(L), .RETRY_MAX(RM)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // device model
  logic [DW-1:0] mem [256];
  int dconf = 0, daddr = 0, inj = 0;
  bit unlocked = 0;
  logic p_ic = 0, p_ia = 0, p_ph = 1;
  logic [DW-1:0] rd = '0;
  assign bus_in = rd;
  initial for (int i = 0; i < 256; i++) mem[i] = '1;
  always @(negedge clk) begin
    if (!rst_add) begin daddr = 0; unlocked = 0; end
    else if (inc_add && !p_ia) daddr++;
    if (!rst_conf) dconf = 0;
    else if (inc_conf && !p_ic) dconf++;
    if (phase_n && !p_ph) begin
      if (dconf == 2) unlocked = 1;
      if (dconf == 3 && unlocked && bus_oe) mem[daddr] = mem[daddr] & bus_out;
      if (dconf == 1) begin
        rd = mem[daddr] ^ ((inj > 0) ? 8'h01 : 8'h00);
        if (inj > 0) inj--;
      end
    end
    p_ic = inc_conf; p_ia = inc_add; p_ph = phase_n;
  end

  // reference model
  logic [7:0] q [$];
  bit bra = 0, berr = 0;
  int bcur = 0;

  function automatic logic [7:0] v(bit ra, bit rc, bit ic, bit ia, bit ph, bit oe, bit dn);
    return {ra, rc, ic, ia, ph, oe, dn, 1'b0};
  endfunction
  task automatic push(logic [7:0] x, int n);
    for (int i = 0; i < n; i++) q.push_back(x);
  endtask

  task automatic chk(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic run_req(int a, logic [DW-1:0] d, int n_bad, string r);
    int writes;
    bit good;
    logic [7:0] got;
    good = (n_bad <= RM);
    writes = good ? n_bad + 1 : RM + 1;
    if (!bra || a < bcur) begin   // R2 restart and unlock
      push(v(0,0,0,0,1,0,0), G);
      bra = 1; bcur = 0;
      push(v(1,1,0,0,1,0,0), G);
      for (int k = 0; k < 2; k++) begin push(v(1,1,1,0,1,0,0), P); push(v(1,1,0,0,1,0,0), G); end
      push(v(1,1,0,0,0,0,0), S); push(v(1,1,0,0,1,0,0), G);
    end
    for (int w = 0; w < writes; w++) begin
      push(v(1,0,0,0,1,1,0), P); push(v(1,1,0,0,1,1,0), G);            // R3
      for (int k = 0; k < 3; k++) begin push(v(1,1,1,0,1,1,0), P); push(v(1,1,0,0,1,1,0), G); end
      while (bcur < a) begin push(v(1,1,0,1,1,1,0), P); push(v(1,1,0,0,1,1,0), G); bcur++; end
      push(v(1,1,0,0,0,1,0), L); push(v(1,1,0,0,1,1,0), G);
      push(v(1,0,0,0,1,0,0), P); push(v(1,1,0,0,1,0,0), G);            // R5 verify
      push(v(1,1,1,0,1,0,0), P); push(v(1,1,0,0,1,0,0), G);
      push(v(1,1,0,0,0,0,0), S); push(v(1,1,0,0,1,0,0), G);
      push(v(1,0,0,0,1,0,0), P); push(v(1,1,0,0,1,0,0), G);
      push(v(1,1,0,0,1,0, (w == writes - 1) && good), 1);
    end
    inj = n_bad;
    chk(req_ready == 1'b1, "R9", {r, " ready before request"}, req_ready, 1);
    req_addr = AW'(a); req_data = d; req_valid = 1'b1;
    @(posedge clk);
    while (q.size() > 0) begin
      logic [7:0] e;
      @(negedge clk);
      req_valid = 1'b0;
      e = q.pop_front();
      got = {rst_add, rst_conf, inc_conf, inc_add, phase_n, bus_oe, done, req_ready};
      chk(got == e, r, "pin vector", got, e);
      if (e[2]) chk(bus_out == d, "R3", {r, " bus data"}, bus_out, d);
    end
    if (!good) berr = 1;
    @(negedge clk);
    chk(req_ready == !berr && err == berr && !done, good ? "R5" : "R7",
        {r, " idle after request"}, {req_ready, err}, {!berr, berr});
    if (good) chk(mem[a] == d, "R3", {r, " device byte"}, mem[a], d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({rst_add, rst_conf, inc_conf, inc_add, phase_n, bus_oe, req_ready, done, err} == 9'b000010100,
        "R1", "reset outputs", {rst_add, rst_conf, inc_conf, inc_add, phase_n, bus_oe, req_ready, done, err}, 9'b000010100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !err, "R1", "ready after reset", {req_ready, err}, 2'b10);
    run_req(0, 8'hA5, 0, "R2");   // first byte: restart, no address step
    run_req(1, 8'h3C, 0, "R4");   // sequential: one inc_add
    run_req(4, 8'h0F, 0, "R3");   // jump of three
    run_req(5, 8'h96, 1, "R6");   // one bad readback
    run_req(2, 8'h5A, 0, "R2");   // backward target restarts
    run_req(3, 8'hC3, RM, "R6");  // exactly the allowed repeats
    run_req(7, 8'h77, RM + 1, "R7");
    req_valid = 1'b1; req_addr = 8'd9; req_data = 8'h11;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk({rst_add, rst_conf, inc_conf, inc_add, phase_n, bus_oe, req_ready, err} == 8'b11001001,
          "R7", "request ignored after error",
          {rst_add, rst_conf, inc_conf, inc_add, phase_n, bus_oe, req_ready, err}, 8'b11001001);
    end
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk({rst_add, rst_conf, phase_n, req_ready, err} == 5'b00110, "R1", "reset clears error",
        {rst_add, rst_conf, phase_n, req_ready, err}, 5'b00110);
    rst_n = 1'b1;
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule